// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects every reset cause of a small microcontroller core and turns them into one synchronous, active-high chip reset. The causes are an asynchronous power-on input, a filtered external active-low reset pin, a gated brown-out detector, a watchdog timeout, a reset instruction, and stack overflow and underflow strobes. A sleep flag from the core decides whether a pin reset counts as a running or a sleeping pin reset. It also decides whether a watchdog timeout resets the chip or only wakes the core with a one-cycle pulse.

The chip reset behaves as a set/reset latch. Any cause sets it. Release follows one of two timings. Power-on and brown-out run a power-up timer, which counts internal timer ticks, followed by an oscillator start-up timer, which counts clock cycles. Each timer has its own enable. Every other cause uses a short fixed release. While a level cause is still present (the pin held low, or brown-out still detected), the reset stays asserted and the timers have not started.

The block keeps a record of the most recent cause. It also keeps five active-low status flags that software reads and can partly restore. The external reset pin is an input only: the block never drives it, including when an internal cause resets the chip.

Top module: `rst_hub`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is 1, `wake_o` is 0, `cause_o` is 8'h01 and `flags_o` is 5'b11101. Flag bit map, all active-low: [4] reset-instruction, [3] timeout, [2] power-down, [1] power-on, [0] brown-out.
- R2: After power-on or brown-out, `chip_rst_o` stays high for (P + O) cycles, counted from the last clock edge at which the cause was present.
  - P is 1024 edges that carry `tick_i`, or 1 when `pwrt_en_i` is 0.
  - O is 1024 clock cycles when `ost_en_i` is 1, or 0 when it is 0.
  - While `tick_i` stays low, the power-up timer does not advance.
- R3: A reset instruction, stack overflow, stack underflow or running watchdog timeout asserts `chip_rst_o` from the next edge on. The reset then releases exactly 2 cycles after the last edge at which the cause was present.
- R4: `ext_rst_n_i` low at fewer than 4 consecutive clock edges causes no reset. Low at 4 or more consecutive edges causes a reset on the first later edge at which the filter is full. The reset then releases 2 cycles after the edge at which the pin is seen high again.
- R5: A filtered pin reset sets `cause_o` to 8'h02 when `sleep_i` is 0 and to 8'h04 when `sleep_i` is 1.
- R6: `bor_det_i` causes a reset only while `bor_en_i` is 1. An enabled brown-out clears flag[0]. A brown-out while `bor_en_i` is 0 leaves `chip_rst_o`, `cause_o` and `flags_o` unchanged.
- R7: `wdt_to_i` while `sleep_i` is 1 raises `wake_o` for exactly one cycle, even when the timeout is held. It does not assert `chip_rst_o`, it leaves `cause_o` unchanged, and it clears flag[3].
- R8: The reset instruction clears flag[4], any watchdog timeout clears flag[3], and a rise of `sleep_i` clears flag[2]. A one-cycle `flag_set_i` restores flags to 1: bit 0 restores flag[0], bit 1 restores flag[1], bit 2 restores flag[2+2].
- R9: `cause_o` holds the vector of causes present at the last reset edge. Bit positions:
  - 0: power-on
  - 1: pin while running
  - 2: pin while asleep
  - 3: watchdog while running
  - 4: brown-out
  - 5: reset instruction
  - 6: stack overflow
  - 7: stack underflow
- R10: A level cause held for many cycles (pin low, or brown-out detected) keeps `chip_rst_o` high for the whole time. Release timing counts only from its removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core oscillator clock |
| por_i | input | 1 | Asynchronous power-on reset, active high |
| tick_i | input | 1 | Internal timer tick enable for the power-up timer |
| ext_rst_n_i | input | 1 | External reset pin, active low, never driven |
| bor_det_i | input | 1 | Brown-out detector output |
| bor_en_i | input | 1 | Brown-out reset enable |
| wdt_to_i | input | 1 | Watchdog timeout strobe |
| rst_instr_i | input | 1 | Reset instruction strobe |
| stk_ovf_i | input | 1 | Stack overflow strobe |
| stk_unf_i | input | 1 | Stack underflow strobe |
| sleep_i | input | 1 | Core sleep state |
| pwrt_en_i | input | 1 | Power-up timer enable |
| ost_en_i | input | 1 | Oscillator start-up timer enable |
| flag_set_i | input | 3 | Flag restore strobes: [0] brown-out, [1] power-on, [2] reset-instruction |
| chip_rst_o | output | 1 | Synchronous chip reset, active high |
| wake_o | output | 1 | One-cycle wake-up pulse |
| cause_o | output | 8 | Causes seen at the last reset edge |
| flags_o | output | 5 | Active-low status flags |

## Verification
A wrong phase or timer count inside the block shows up as a chip reset that releases early or late. Every power-on and brown-out release is therefore measured to the exact cycle over all four enable combinations, and every short cause is measured the same way. A wrong filter count shows up as a reset on a 3-cycle glitch, or as no reset on a 4-cycle low; both appear within two cycles of the pin rising. Flag and cause errors appear as wrong values on the cycle after the event that should have changed them. The watchdog path is checked for a wake pulse that is doubled or missing, and for a reset that leaks through during sleep.

// File: rtl/rst_hub.sv
module rst_hub #(
  parameter int PWRT_W    = 10,
  parameter int OST_W     = 10,
  parameter int FILT_LEN  = 4,
  parameter int SHORT_CYC = 2
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       tick_i,
  input  logic       ext_rst_n_i,
  input  logic       bor_det_i,
  input  logic       bor_en_i,
  input  logic       wdt_to_i,
  input  logic       rst_instr_i,
  input  logic       stk_ovf_i,
  input  logic       stk_unf_i,
  input  logic       sleep_i,
  input  logic       pwrt_en_i,
  input  logic       ost_en_i,
  input  logic [2:0] flag_set_i,
  output logic       chip_rst_o,
  output logic       wake_o,
  output logic [7:0] cause_o,
  output logic [4:0] flags_o
);

  localparam int CW = (PWRT_W > OST_W) ? PWRT_W : OST_W;
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] PW_MAX = CW'((1 << PWRT_W) - 1);
  localparam logic [CW-1:0] OS_MAX = CW'((1 << OST_W) - 1);
  localparam logic [CW-1:0] SC_MAX = CW'(SHORT_CYC - 1);

  typedef enum logic [1:0] {RUN, PWRT, OST, SHRT} ph_t;

  ph_t           ph;
  logic [CW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic          rst_q, w_q, wake_q, slp_q;
  logic [7:0]    cause_q;
  logic [4:0]    flg;

  // pin glitch filter: counts consecutive low samples, saturates when full
  wire pin_ok = (fcnt == FW'(FILT_LEN));

  always_ff @(posedge clk_i or posedge por_i)
    if (por_i)            fcnt <= '0;
    else if (ext_rst_n_i) fcnt <= '0;
    else if (!pin_ok)     fcnt <= fcnt + 1'b1;

  wire bor_hit = bor_det_i & bor_en_i;
  wire wdt_run = wdt_to_i & ~sleep_i;
  wire wdt_slp = wdt_to_i & sleep_i;

  logic [7:0] cz;
  assign cz = {stk_unf_i, stk_ovf_i, rst_instr_i, bor_hit, wdt_run,
               pin_ok & sleep_i, pin_ok & ~sleep_i, 1'b0};

  // reset latch and start-up sequencing
  always_ff @(posedge clk_i or posedge por_i)
    if (por_i) begin
      ph      <= PWRT;
      cnt     <= '0;
      rst_q   <= 1'b1;
      cause_q <= 8'h01;
    end else if (|cz) begin
      rst_q   <= 1'b1;
      cnt     <= '0;
      cause_q <= cz;
      ph      <= (bor_hit || ph == PWRT || ph == OST) ? PWRT : SHRT;
    end else begin
      case (ph)
        PWRT:
          if (!pwrt_en_i || (tick_i && cnt == PW_MAX)) begin
            cnt <= '0;
            if (ost_en_i) ph <= OST;
            else begin ph <= RUN; rst_q <= 1'b0; end
          end else if (tick_i) cnt <= cnt + 1'b1;
        OST:
          if (cnt == OS_MAX) begin ph <= RUN; rst_q <= 1'b0; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        SHRT:
          if (cnt == SC_MAX) begin ph <= RUN; rst_q <= 1'b0; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end

  // wake-up pulse on a sleeping watchdog timeout
  always_ff @(posedge clk_i or posedge por_i)
    if (por_i) begin
      w_q    <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      w_q    <= wdt_slp;
      wake_q <= wdt_slp & ~w_q;
    end

  // flags {ri, to, pd, por, bor}, active low; clearing wins over restore
  always_ff @(posedge clk_i or posedge por_i)
    if (por_i) begin
      flg   <= 5'b11101;
      slp_q <= 1'b0;
    end else begin
      slp_q <= sleep_i;
      if (flag_set_i[0])      flg[0] <= 1'b1;
      if (flag_set_i[1])      flg[1] <= 1'b1;
      if (flag_set_i[2])      flg[4] <= 1'b1;
      if (bor_hit)            flg[0] <= 1'b0;
      if (sleep_i && !slp_q)  flg[2] <= 1'b0;
      if (wdt_to_i)           flg[3] <= 1'b0;
      if (rst_instr_i)        flg[4] <= 1'b0;
    end

  assign chip_rst_o = rst_q;
  assign wake_o     = wake_q;
  assign cause_o    = cause_q;
  assign flags_o    = flg;

  a_r3_cause_sets_rst: assert property (@(posedge clk_i) disable iff (por_i)
    (|cz) |=> chip_rst_o);
  a_r3_no_release_under_cause: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(chip_rst_o) |-> ($past(cz) == 8'h00));
  a_r7_wake_no_rst: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_slp && cz == 8'h00 && !chip_rst_o) |=> !chip_rst_o);
  a_r7_wake_single: assert property (@(posedge clk_i) disable iff (por_i)
    wake_o |=> !wake_o);
  a_r6_bor_gated: assert property (@(posedge clk_i) disable iff (por_i)
    (bor_det_i && !bor_en_i && !flag_set_i[0]) |=> $stable(flags_o[0]));
  a_r8_ri_clear: assert property (@(posedge clk_i) disable iff (por_i)
    rst_instr_i |=> !flags_o[4]);

endmodule

// File: tb/test_rst_hub.sv
module test_rst_hub;
  logic clk = 1'b0;
  logic por_i = 1'b1, tick_i = 1'b1, ext_rst_n_i = 1'b1, bor_det_i = 1'b0, bor_en_i = 1'b1;
  logic wdt_to_i = 1'b0, rst_instr_i = 1'b0, stk_ovf_i = 1'b0, stk_unf_i = 1'b0, sleep_i = 1'b0;
  logic pwrt_en_i = 1'b1, ost_en_i = 1'b1;
  logic [2:0] flag_set_i = 3'b000;
  logic chip_rst_o, wake_o;
  logic [7:0] cause_o;
  logic [4:0] flags_o;

  int n_chk = 0, n_fail = 0;
  logic e_ri = 1, e_to = 1, e_pd = 1, e_por = 0, e_bor = 1;
  logic [7:0] e_cause = 8'h01;

  always #10 clk = ~clk;

  rst_hub i_rst_hub (
    .clk_i(clk), .por_i(por_i), .tick_i(tick_i), .ext_rst_n_i(ext_rst_n_i),
    .bor_det_i(bor_det_i), .bor_en_i(bor_en_i), .wdt_to_i(wdt_to_i),
    .rst_instr_i(rst_instr_i), .stk_ovf_i(stk_ovf_i), .stk_unf_i(stk_unf_i),
    .sleep_i(sleep_i), .pwrt_en_i(pwrt_en_i), .ost_en_i(ost_en_i),
    .flag_set_i(flag_set_i), .chip_rst_o(chip_rst_o), .wake_o(wake_o),
    .cause_o(cause_o), .flags_o(flags_o));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eflags();
    return {27'd0, e_ri, e_to, e_pd, e_por, e_bor};
  endfunction

  function automatic int dur(logic p, logic o);
    return (p ? 1024 : 1) + (o ? 1024 : 0);
  endfunction

  task automatic count_rst(output int n);
    n = 0;
    while (chip_rst_o && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic strobe(int k);
    @(negedge clk);
    case (k)
      3: wdt_to_i = 1'b1;
      4: bor_det_i = 1'b1;
      5: rst_instr_i = 1'b1;
      6: stk_ovf_i = 1'b1;
      default: stk_unf_i = 1'b1;
    endcase
    @(negedge clk);
    {wdt_to_i, bor_det_i, rst_instr_i, stk_ovf_i, stk_unf_i} = '0;
  endtask

  task automatic restore(logic [2:0] m);
    @(negedge clk);
    flag_set_i = m;
    @(negedge clk);
    flag_set_i = 3'b000;
    if (m[0]) e_bor = 1;
    if (m[1]) e_por = 1;
    if (m[2]) e_ri = 1;
    chk("R8 restore", flags_o, eflags());
  endtask

  task automatic pin_low(int len);
    int n;
    @(negedge clk);
    ext_rst_n_i = 1'b0;
    repeat (len) @(negedge clk);
    if (len >= 5) chk("R10 pin held keeps reset", chip_rst_o, 1);
    ext_rst_n_i = 1'b1;
    @(negedge clk);
    count_rst(n);
    if (len >= 4) begin
      e_cause = sleep_i ? 8'h04 : 8'h02;
      chk("R4 filtered pin release", n, 2);
      chk("R5 pin cause", cause_o, e_cause);
    end else begin
      chk("R4 glitch ignored", n, 0);
      chk("R4 glitch cause unchanged", cause_o, e_cause);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset rst", chip_rst_o, 1);
    chk("R1 reset wake", wake_o, 0);
    chk("R1 reset cause", cause_o, 8'h01);
    chk("R1 reset flags", flags_o, 5'b11101);

    // power-on release over every enable combination
    for (int e = 0; e < 4; e++) begin
      pwrt_en_i = e[0];
      ost_en_i  = e[1];
      por_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      por_i = 1'b0;
      count_rst(n);
      chk("R2 power-on duration", n, dur(e[0], e[1]));
      chk("R1 flags after power-on", flags_o, 5'b11101);
      chk("R9 power-on cause", cause_o, 8'h01);
    end
    e_ri = 1; e_to = 1; e_pd = 1; e_por = 0; e_bor = 1; e_cause = 8'h01;
    restore(3'b111);

    // brown-out release over every enable combination
    for (int e = 0; e < 4; e++) begin
      pwrt_en_i = e[0];
      ost_en_i  = e[1];
      strobe(4);
      count_rst(n);
      e_bor = 0; e_cause = 8'h10;
      chk("R6 brown-out duration", n, dur(e[0], e[1]));
      chk("R9 brown-out cause", cause_o, e_cause);
      chk("R6 brown-out flag", flags_o, eflags());
      restore(3'b001);
    end

    // gated brown-out
    bor_en_i = 1'b0;
    strobe(4);
    chk("R6 gated no reset", chip_rst_o, 0);
    @(negedge clk);
    chk("R6 gated flags", flags_o, eflags());
    chk("R6 gated cause", cause_o, e_cause);
    bor_en_i = 1'b1;

    // short causes
    for (int k = 3; k < 8; k++) begin
      if (k == 4) continue;
      strobe(k);
      count_rst(n);
      e_cause = 8'(1 << k);
      if (k == 3) e_to = 0;
      if (k == 5) e_ri = 0;
      chk("R3 short release", n, 2);
      chk("R9 short cause", cause_o, e_cause);
      chk("R8 short flags", flags_o, eflags());
    end
    restore(3'b100);

    // pin filter sweep while running
    for (int len = 1; len <= 6; len++) pin_low(len);
    pin_low(30);

    // pin while asleep
    @(negedge clk);
    sleep_i = 1'b1;
    @(negedge clk);
    e_pd = 0;
    chk("R8 sleep clears pd", flags_o, eflags());
    pin_low(3);
    pin_low(4);

    // watchdog during sleep: wake only
    strobe(3);
    e_to = 0;
    chk("R7 wake pulse", wake_o, 1);
    chk("R7 no reset", chip_rst_o, 0);
    @(negedge clk);
    chk("R7 wake one cycle", wake_o, 0);
    chk("R7 cause unchanged", cause_o, e_cause);
    chk("R7 timeout flag", flags_o, eflags());
    n = 0;
    wdt_to_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      n += int'(wake_o);
      if (chip_rst_o) n += 100;
    end
    wdt_to_i = 1'b0;
    chk("R7 held timeout single wake", n, 1);
    @(negedge clk);
    sleep_i = 1'b0;

    // held brown-out, then tick gating
    pwrt_en_i = 1'b1; ost_en_i = 1'b1;
    @(negedge clk);
    bor_det_i = 1'b1;
    repeat (50) @(negedge clk);
    chk("R10 held brown-out keeps reset", chip_rst_o, 1);
    bor_det_i = 1'b0;
    count_rst(n);
    chk("R10 held brown-out release", n, dur(1, 1));
    tick_i = 1'b0;
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    repeat (2000) @(negedge clk);
    chk("R2 no tick holds reset", chip_rst_o, 1);
    tick_i = 1'b1;
    count_rst(n);
    chk("R2 tick resumes", n, dur(1, 1));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule